// File: doc/BRIEF.md
# Two-Road Junction Lamp Controller

This block runs the lamps of a crossing between a North road and an East road. It is a Moore machine with four phases: North green, North amber, East green and East amber. Each phase has a fixed lamp pattern, a fixed dwell length and a row of four successor phases. The registered code from two car detectors picks the successor.

A prescaler divides the system clock down to a one-cycle tick every 10 ms. On entry to a phase, a dwell counter is loaded with that phase's length in ticks. The prescaler restarts on the same edge. The lamps hold while the counter runs down. On the last cycle of the dwell, the synchronized detector code is looked up in the phase's row, and the machine moves on. A move back into the same phase also reloads the full dwell. The detector lines pass through a synchronizer of two flops before they are used.

The tick period and both dwell lengths are parameters. A bench can therefore shrink them and still keep every ratio.

Top module: `junction_lamp_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the controller enters North green (`lamps` = 0x21) with a full long dwell. The first phase change after release comes exactly LONG_TICKS*TICK_CYCLES rising edges after the last edge with `rst` high.
- R2: The `lamps` bits are 6 bits wide, with one fixed pattern per phase: North green 0x21, North amber 0x22, East green 0x0C, East amber 0x14. No other value ever appears.
- R3: Each phase is held for exactly DWELL*TICK_CYCLES clock cycles. DWELL is LONG_TICKS (default 3000) for the two green phases and SHORT_TICKS (default 500) for the two amber phases. TICK_CYCLES defaults to 10 ms at 125 MHz.
- R4: At the end of North green, the successor depends on the detector code `carSense[0]`, where bit 0 means cars waiting East and bit 1 means cars waiting North. Codes 00 and 10 re-enter North green. Codes 01 and 11 go to North amber.
- R5: At the end of North amber, the next phase is always East green, whatever the detector code.
- R6: At the end of East green, codes 00 and 01 re-enter East green. Codes 10 and 11 go to East amber.
- R7: At the end of East amber, the next phase is always North green, whatever the detector code.
- R8: The detector code is used only on the final cycle of a dwell. A code that changes during the dwell and returns to its old value before that window has no effect on the phase sequence.
- R9: The code used is the input value captured two rising edges before the phase-change edge. A change applied in the final cycle of the dwell is not seen by that decision.
- R10: A move back into the same phase reloads the whole dwell, so the re-entered phase again lasts DWELL*TICK_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| carSense | input | 2 | Asynchronous detector lines: bit 0 East waiting, bit 1 North waiting |
| lamps | output | 6 | Lamp drive pattern of the current phase |

## Verification
The hardest case to reach is the edge of the decision window. The detector code must be seen as it stood two edges before the phase change, and not one edge later. The stimulus counts cycles from each phase entry. It then switches the detector lines in the dwell's final cycle, and separately pulses them in mid-dwell, and checks that neither alters the successor. Same-phase re-entry is another case that is easy to miss. It is exposed by letting North green repeat once, then requesting a change and checking that the change lands exactly one full dwell after the re-entry.

// File: rtl/junction_pkg.sv
package junction_pkg;

  localparam int LAMP_W = 6;

  typedef enum logic [1:0] {
    ST_GON   = 2'd0,
    ST_WAITN = 2'd1,
    ST_GOE   = 2'd2,
    ST_WAITE = 2'd3
  } lightState_t;

  // Strobes from control into the timing datapath
  typedef struct packed {
    logic reload;      // phase entry: restart prescaler, load dwell
    logic shortDwell;  // which dwell length the entered phase uses
  } dwellCmd_t;

  typedef struct packed {
    logic [LAMP_W-1:0]      lamps;
    logic                   shortDwell;
    lightState_t [3:0]      nxt;       // indexed by detector code
  } phaseRow_t;

  function automatic phaseRow_t phaseRow(input lightState_t s);
    phaseRow_t r;
    case (s)
      ST_GON: begin
        r.lamps = 6'h21; r.shortDwell = 1'b0;
        r.nxt = {ST_WAITN, ST_GON, ST_WAITN, ST_GON};
      end
      ST_WAITN: begin
        r.lamps = 6'h22; r.shortDwell = 1'b1;
        r.nxt = {ST_GOE, ST_GOE, ST_GOE, ST_GOE};
      end
      ST_GOE: begin
        r.lamps = 6'h0C; r.shortDwell = 1'b0;
        r.nxt = {ST_WAITE, ST_WAITE, ST_GOE, ST_GOE};
      end
      default: begin
        r.lamps = 6'h14; r.shortDwell = 1'b1;
        r.nxt = {ST_GON, ST_GON, ST_GON, ST_GON};
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/junction_timer.sv
module junction_timer
  import junction_pkg::*;
#(
  parameter int TICK_CYCLES = 1250000,
  parameter int LONG_TICKS  = 3000,
  parameter int SHORT_TICKS = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic [1:0] sensRaw,
  input  dwellCmd_t cmd,
  output logic      dwellDone,
  output logic [1:0] sensCode
);

  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int DW = $clog2(MAXT + 1);
  localparam logic [PW-1:0] PRESC_LAST = PW'(TICK_CYCLES - 1);
  localparam logic [DW-1:0] LONG_LD    = DW'(LONG_TICKS);
  localparam logic [DW-1:0] SHORT_LD   = DW'(SHORT_TICKS);
  localparam logic [DW-1:0] DW_ONE     = DW'(1);

  // Detector synchronizer chain
  logic [1:0] syncQ [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) syncQ[0] <= 2'b00;
    else     syncQ[0] <= sensRaw;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : gSync
    always_ff @(posedge clk) begin
      if (rst) syncQ[g] <= 2'b00;
      else     syncQ[g] <= syncQ[g-1];
    end
  end

  assign sensCode = syncQ[SYNC_STAGES-1];

  // Prescaler and dwell counter
  logic [PW-1:0] prescCnt;
  logic [DW-1:0] dwellCnt;
  logic          tick;

  assign tick      = (prescCnt == PRESC_LAST);
  assign dwellDone = tick && (dwellCnt == DW_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      prescCnt <= '0;
      dwellCnt <= LONG_LD;
    end else if (cmd.reload) begin
      prescCnt <= '0;
      dwellCnt <= cmd.shortDwell ? SHORT_LD : LONG_LD;
    end else if (tick) begin
      prescCnt <= '0;
      dwellCnt <= dwellCnt - DW_ONE;
    end else begin
      prescCnt <= prescCnt + 1'b1;
    end
  end

endmodule

// File: rtl/junction_ctrl.sv
module junction_ctrl
  import junction_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              dwellDone,
  input  logic [1:0]        sensCode,
  output lightState_t       curState,
  output logic [LAMP_W-1:0] lamps,
  output dwellCmd_t         cmd
);

  phaseRow_t   curRow;
  phaseRow_t   nextRow;
  lightState_t nextState;

  always_comb begin
    curRow         = phaseRow(curState);
    nextState      = curRow.nxt[sensCode];
    nextRow        = phaseRow(nextState);
    lamps          = curRow.lamps;
    cmd.reload     = dwellDone;
    cmd.shortDwell = nextRow.shortDwell;
  end

  always_ff @(posedge clk) begin
    if (rst)            curState <= ST_GON;
    else if (dwellDone) curState <= nextState;
  end

endmodule

// File: rtl/junction_lamp_fsm.sv
module junction_lamp_fsm
  import junction_pkg::*;
#(
  parameter int TICK_CYCLES = 1250000,
  parameter int LONG_TICKS  = 3000,
  parameter int SHORT_TICKS = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] carSense,
  output logic [5:0] lamps
);

  lightState_t curState;
  dwellCmd_t   cmd;
  logic        dwellDone;
  logic [1:0]  sensCode;

  junction_timer #(
    .TICK_CYCLES(TICK_CYCLES),
    .LONG_TICKS (LONG_TICKS),
    .SHORT_TICKS(SHORT_TICKS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .sensRaw  (carSense),
    .cmd      (cmd),
    .dwellDone(dwellDone),
    .sensCode (sensCode)
  );

  junction_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .dwellDone(dwellDone),
    .sensCode (sensCode),
    .curState (curState),
    .lamps    (lamps),
    .cmd      (cmd)
  );

endmodule

// File: rtl/junction_lamp_sva.sv
module junction_lamp_sva
  import junction_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [5:0]  lamps,
  input lightState_t curState,
  input logic        dwellDone,
  input logic [1:0]  sensCode
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (curState == ST_GON && lamps == 6'h21));

  a_r2_lamp_legal: assert property (@(posedge clk) disable iff (rst)
    lamps inside {6'h21, 6'h22, 6'h0C, 6'h14});

  a_r3_hold_until_done: assert property (@(posedge clk) disable iff (rst)
    !dwellDone |=> $stable(curState));

  a_r4_gon_to_waitn: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_GON && dwellDone && sensCode[0]) |=> curState == ST_WAITN);

  a_r4_gon_stay: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_GON && dwellDone && !sensCode[0]) |=> curState == ST_GON);

  a_r5_waitn_to_goe: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_WAITN && dwellDone) |=> curState == ST_GOE);

  a_r6_goe_to_waite: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_GOE && dwellDone && sensCode[1]) |=> curState == ST_WAITE);

  a_r6_goe_stay: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_GOE && dwellDone && !sensCode[1]) |=> curState == ST_GOE);

  a_r7_waite_to_gon: assert property (@(posedge clk) disable iff (rst)
    (curState == ST_WAITE && dwellDone) |=> curState == ST_GON);

endmodule

bind junction_lamp_fsm junction_lamp_sva u_sva (.*);

// File: tb/junction_lamp_fsm_tb.sv
module junction_lamp_fsm_tb;

  localparam int TCY   = 4;
  localparam int LONGT = 6;
  localparam int SHRT  = 3;
  localparam int GOCY  = TCY * LONGT;  // 24 cycles
  localparam int WTCY  = TCY * SHRT;   // 12 cycles

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] carSense = 2'b00;
  logic [5:0] lamps;

  int checkCnt = 0;
  int failCnt  = 0;

  junction_lamp_fsm #(
    .TICK_CYCLES(TCY),
    .LONG_TICKS (LONGT),
    .SHORT_TICKS(SHRT),
    .SYNC_STAGES(2)
  ) u_dut (
    .clk     (clk),
    .rst     (rst),
    .carSense(carSense),
    .lamps   (lamps)
  );

  always #4 clk = ~clk;

  task automatic advance(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [5:0] exp);
    checkCnt++;
    if (lamps !== exp) begin
      failCnt++;
      $display("FAIL %s: lamps=0x%02h expected=0x%02h", req, lamps, exp);
    end
  endtask

  // Holds a phase for a full dwell: checks old value one cycle before, new after
  task automatic dwellThen(input string req, input int cyc,
                           input logic [5:0] cur, input logic [5:0] nxt);
    advance(cyc - 1);
    check(req, cur);
    advance(1);
    check(req, nxt);
  endtask

  task automatic tReset();
    rst = 1'b1;
    carSense = 2'b00;
    advance(3);
    check("R1 reset lamps", 6'h21);
    rst = 1'b0;
  endtask

  task automatic tGoNHold();
    carSense = 2'b00;
    dwellThen("R4 goN code00 stays", GOCY, 6'h21, 6'h21);
    carSense = 2'b10;
    dwellThen("R4 goN code10 stays", GOCY, 6'h21, 6'h21);
  endtask

  task automatic tMidGlitch();
    carSense = 2'b00;
    advance(5);
    carSense = 2'b01;
    advance(4);
    carSense = 2'b00;
    advance(GOCY - 1 - 9);
    check("R8 mid-dwell pulse ignored, before end", 6'h21);
    advance(1);
    check("R8 mid-dwell pulse ignored", 6'h21);
  endtask

  task automatic tLateChange();
    carSense = 2'b00;
    advance(GOCY - 1);
    carSense = 2'b01;
    advance(1);
    check("R9 last-cycle change not seen", 6'h21);
  endtask

  task automatic tReentryAndNorthAmber();
    carSense = 2'b01;
    dwellThen("R10 full dwell after re-entry then R4 code01", GOCY, 6'h21, 6'h22);
    carSense = 2'b10;
    dwellThen("R5 waitN to goE, R3 short dwell", WTCY, 6'h22, 6'h0C);
  endtask

  task automatic tGoEAndEastAmber();
    carSense = 2'b00;
    dwellThen("R6 goE code00 stays", GOCY, 6'h0C, 6'h0C);
    carSense = 2'b01;
    dwellThen("R6 goE code01 stays", GOCY, 6'h0C, 6'h0C);
    carSense = 2'b11;
    dwellThen("R6 goE code11 to waitE", GOCY, 6'h0C, 6'h14);
    dwellThen("R7 waitE to goN", WTCY, 6'h14, 6'h21);
  endtask

  task automatic tNorthAmberCode11();
    carSense = 2'b11;
    dwellThen("R4 goN code11 to waitN", GOCY, 6'h21, 6'h22);
    carSense = 2'b00;
    dwellThen("R5 waitN code00 to goE", WTCY, 6'h22, 6'h0C);
  endtask

  task automatic tResetMidDwell();
    carSense = 2'b10;
    advance(7);
    check("R2 goE pattern mid-dwell", 6'h0C);
    rst = 1'b1;
    advance(1);
    check("R1 reset during goE", 6'h21);
    advance(2);
    rst = 1'b0;
    carSense = 2'b01;
    dwellThen("R1 full dwell after reset", GOCY, 6'h21, 6'h22);
  endtask

  initial begin
    #(8 * 100000);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    tReset();
    tGoNHold();
    tMidGlitch();
    tLateChange();
    tReentryAndNorthAmber();
    tGoEAndEastAmber();
    tNorthAmberCode11();
    tResetMidDwell();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule